// File: doc/BRIEF.md
# Universal Bidirectional Bus Register

This block moves a data word in two directions, from port A to port B and from port B to port A. Each direction has its own storage word and its own set of four controls: a latch enable, a transfer clock, an active-low clock enable and an active-low output enable. With these controls a direction can run in one of four modes:

- **Transparent:** the output follows the input.
- **Clocked:** the input is captured on a rising transfer-clock edge.
- **Clock-inhibited:** rising edges are ignored.
- **Latched:** the last value is held while the controls stay steady.

The block is a synchronous model. A fast system clock samples every control and data input. A rising transfer-clock edge is found by comparing each sample with the one before it. A storage word changes only on a system-clock edge, so every path has one registered stage of latency. Each output port does not drive a tri-state pin. It gives a data word and a separate drive flag, and the pad logic of the chip turns that flag into a real output enable. When the port is released, its storage keeps working.

Top module: `bidir_bus_register`

## Requirements
- R1: The word width is the parameter `WIDTH`, with a default of 18 bits. There are two directions: A-to-B (`aIn` to `bOut`) and B-to-A (`bIn` to `aOut`). Each direction has its own controls and its own storage word.
- R2: If the latch enable is 1 at a system-clock edge, the output after that edge equals the input sampled at that edge. This holds whatever the levels of the transfer clock and the clock enable.
- R3: A capture happens at a system-clock edge when all of these are true: the latch enable is 0, the active-low clock enable is 0, the transfer clock is sampled 1 at this edge and it was sampled 0 at the previous edge. The captured input is the one sampled at this edge, and it appears on the output after that edge.
- R4: If the clock enable is 1 and the latch enable is 0, a rising transfer clock does not change the output.
- R5: If the latch enable is 0 and the transfer clock is steady (high or low), or only falls, the output keeps its stored value while the input changes.
- R6: When the latch enable falls while the transfer clock is high, the output keeps the value taken at the last edge where the latch enable was 1. The clock staying high after that causes no capture.
- R7: The drive flag after a system-clock edge equals the inverse of the active-low output enable sampled at that edge. When the port is released, captures still take place and show on the output word.
- R8: A synchronous active-low reset clears both storage words to zero and clears both drive flags. The edge detector is reset as if it had last seen the clock high, so a transfer clock held high through the release of reset causes no capture.
- R9: The clock enable is sampled at the same system-clock edge as the rising clock sample. A value of 0 at that edge allows the capture, even if it was 1 one cycle earlier. A value of 1 at that edge blocks the capture.
- R10: Activity in one direction never changes the output word or the drive flag of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Synchronous active-low reset |
| aIn | input | WIDTH | Data arriving at port A |
| abOutEnN | input | 1 | A-to-B output enable, active low |
| abLatchEn | input | 1 | A-to-B latch enable, high means transparent |
| abXferClk | input | 1 | A-to-B transfer clock |
| abClkEnN | input | 1 | A-to-B clock enable, active low |
| bOut | output | WIDTH | Data word presented at port B |
| bDrive | output | 1 | High when port B must be driven |
| bIn | input | WIDTH | Data arriving at port B |
| baOutEnN | input | 1 | B-to-A output enable, active low |
| baLatchEn | input | 1 | B-to-A latch enable, high means transparent |
| baXferClk | input | 1 | B-to-A transfer clock |
| baClkEnN | input | 1 | B-to-A clock enable, active low |
| aOut | output | WIDTH | Data word presented at port A |
| aDrive | output | 1 | High when port A must be driven |

## Verification
The bench goes after these corner cases, and each one shows how a wrong design would fail:

- **Latch enable falls while the transfer clock is high.** A detector that treats the level as an edge would capture the value present one cycle later.
- **Transfer clock held high across the release of reset.** A detector reset to a low sample would make a false capture.
- **Clock enable changes in the same cycle as the rising clock sample.** A design that uses a delayed clock enable would capture when it should block, and block when it should capture.
- **Released port.** A design that gates storage with the output enable would lose a capture made while the port was released.
- **Falling transfer clock.** A design that treats it as an edge would corrupt the held value.
- **Idle direction.** Every pass checks the idle direction, so any leak between the two channels shows up.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  // Strobes from one direction's control to its datapath.
  typedef struct packed {
    logic load;     // write the input word into storage this cycle
    logic driveOn;  // registered port drive flag
  } xferStrobe_t;
endpackage

// File: rtl/ubr_ctrl.sv
module ubr_ctrl
  import ubr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        latchEn,
  input  logic        clkEnN,
  input  logic        xferClk,
  input  logic        outEnN,
  output xferStrobe_t strobe
);
  logic prevClk;
  logic driveQ;
  logic clkRise;

  // Previous transfer-clock sample; reset to 1 so a clock high at release is no edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk <= 1'b1;
      driveQ  <= 1'b0;
    end else begin
      prevClk <= xferClk;
      driveQ  <= ~outEnN;
    end
  end

  always_comb begin
    clkRise        = xferClk & ~prevClk;
    strobe.load    = latchEn | (~clkEnN & clkRise);
    strobe.driveOn = driveQ;
  end

  // R7: drive flag follows the inverted output enable one cycle later
  assert_drive_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (strobe.driveOn == !$past(outEnN)));
endmodule

// File: rtl/ubr_datapath.sv
module ubr_datapath
  import ubr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  xferStrobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut,
  output logic             drive
);
  logic [WIDTH-1:0] storeQ;

  always_ff @(posedge clk) begin
    if (!rstN)            storeQ <= '0;
    else if (strobe.load) storeQ <= dataIn;
  end

  assign dataOut = storeQ;
  assign drive   = strobe.driveOn;

  // R5: without a load strobe the stored word does not move
  assert_hold_without_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(storeQ));
  // R3: a load strobe writes the word sampled in that cycle
  assert_load_writes_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (storeQ == $past(dataIn)));
endmodule

// File: rtl/bidir_bus_register.sv
module bidir_bus_register
  import ubr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] aIn,
  input  logic             abOutEnN,
  input  logic             abLatchEn,
  input  logic             abXferClk,
  input  logic             abClkEnN,
  output logic [WIDTH-1:0] bOut,
  output logic             bDrive,
  input  logic [WIDTH-1:0] bIn,
  input  logic             baOutEnN,
  input  logic             baLatchEn,
  input  logic             baXferClk,
  input  logic             baClkEnN,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive
);
  localparam int NumDir = 2;  // index 0: A-to-B, index 1: B-to-A

  logic [NumDir-1:0][WIDTH-1:0] dirIn, dirOut;
  logic [NumDir-1:0]            dirLe, dirCen, dirClk, dirOe, dirDrive;

  assign dirIn  = {bIn, aIn};
  assign dirLe  = {baLatchEn, abLatchEn};
  assign dirCen = {baClkEnN, abClkEnN};
  assign dirClk = {baXferClk, abXferClk};
  assign dirOe  = {baOutEnN, abOutEnN};
  assign bOut   = dirOut[0];
  assign aOut   = dirOut[1];
  assign bDrive = dirDrive[0];
  assign aDrive = dirDrive[1];

  // R1: two identical, independent channels; R10 follows from separate state
  for (genvar d = 0; d < NumDir; d++) begin : g_dir
    xferStrobe_t strobe;

    ubr_ctrl u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .latchEn (dirLe[d]),
      .clkEnN  (dirCen[d]),
      .xferClk (dirClk[d]),
      .outEnN  (dirOe[d]),
      .strobe  (strobe)
    );

    ubr_datapath #(.WIDTH(WIDTH)) u_dp (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobe),
      .dataIn  (dirIn[d]),
      .dataOut (dirOut[d]),
      .drive   (dirDrive[d])
    );

    // R2: latch enable high gives the sampled input on the next cycle
    assert_transparent_R2: assert property (@(posedge clk) disable iff (!rstN)
      dirLe[d] |=> (dirOut[d] == $past(dirIn[d])));
    // R4: clock enable high blocks captures while not transparent
    assert_clock_inhibit_R4: assert property (@(posedge clk) disable iff (!rstN)
      (!dirLe[d] && dirCen[d]) |=> $stable(dirOut[d]));
    // R3: enabled rising transfer clock captures the sampled input
    assert_clocked_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
      (!dirLe[d] && !dirCen[d] && dirClk[d] && !$past(dirClk[d]) && $past(rstN))
      |=> (dirOut[d] == $past(dirIn[d])));
    // R6: steady transfer clock with latch enable low keeps the word
    assert_latched_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!dirLe[d] && $stable(dirClk[d])) |=> $stable(dirOut[d]));
  end
endmodule

// File: tb/bidir_bus_register_tb.sv
module bidir_bus_register_tb;
  localparam int W = 18;
  localparam int NV = 19;

  typedef struct packed {
    logic         le;
    logic         cen;
    logic         xc;
    logic         oe;
    logic [W-1:0] d;
    logic [W-1:0] e;
    logic         drv;
    logic [3:0]   req;
  } vec_t;

  // Columns: latch enable, clock enable (low active), transfer clock, output enable (low active),
  // data, expected word, expected drive, requirement number.
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,18'h11111,18'h00000,1'b1,4'd5},  // R5 hold from reset value
    '{1'b0,1'b0,1'b1,1'b0,18'h12345,18'h12345,1'b1,4'd3},  // R3 capture
    '{1'b0,1'b0,1'b1,1'b0,18'h2AAAA,18'h12345,1'b1,4'd5},  // R5 steady high
    '{1'b0,1'b0,1'b0,1'b0,18'h15555,18'h12345,1'b1,4'd5},  // R5 falling clock
    '{1'b0,1'b1,1'b1,1'b0,18'h3F0F0,18'h12345,1'b1,4'd4},  // R4 inhibit
    '{1'b0,1'b1,1'b0,1'b0,18'h00FFF,18'h12345,1'b1,4'd4},  // R4
    '{1'b1,1'b1,1'b0,1'b0,18'h00FFF,18'h00FFF,1'b1,4'd2},  // R2 transparent
    '{1'b1,1'b0,1'b1,1'b0,18'h3C3C3,18'h3C3C3,1'b1,4'd2},  // R2 with clock rise
    '{1'b1,1'b0,1'b1,1'b0,18'h0A5A5,18'h0A5A5,1'b1,4'd2},  // R2
    '{1'b0,1'b0,1'b1,1'b0,18'h21212,18'h0A5A5,1'b1,4'd6},  // R6 latch falls, clock high
    '{1'b0,1'b0,1'b0,1'b1,18'h00001,18'h0A5A5,1'b0,4'd7},  // R7 released
    '{1'b0,1'b0,1'b1,1'b1,18'h2BEEF,18'h2BEEF,1'b0,4'd7},  // R7 capture while released
    '{1'b0,1'b0,1'b1,1'b0,18'h00000,18'h2BEEF,1'b1,4'd7},  // R7 driven again
    '{1'b0,1'b0,1'b0,1'b0,18'h3FFFF,18'h2BEEF,1'b1,4'd5},  // R5
    '{1'b0,1'b1,1'b0,1'b0,18'h00000,18'h2BEEF,1'b1,4'd9},  // R9 enable off before edge
    '{1'b0,1'b0,1'b1,1'b0,18'h3FFFF,18'h3FFFF,1'b1,4'd9},  // R9 enable on at edge
    '{1'b0,1'b0,1'b0,1'b0,18'h00000,18'h3FFFF,1'b1,4'd9},  // R9
    '{1'b0,1'b1,1'b1,1'b0,18'h11111,18'h3FFFF,1'b1,4'd9},  // R9 enable off at edge
    '{1'b0,1'b0,1'b1,1'b0,18'h22222,18'h3FFFF,1'b1,4'd5}   // R5 clock already high
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic abOutEnN = 1'b1, abLatchEn = 1'b0, abXferClk = 1'b0, abClkEnN = 1'b1;
  logic baOutEnN = 1'b1, baLatchEn = 1'b0, baXferClk = 1'b0, baClkEnN = 1'b1;
  logic [W-1:0] aOut, bOut;
  logic aDrive, bDrive;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bidir_bus_register #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .aIn(aIn), .abOutEnN(abOutEnN), .abLatchEn(abLatchEn), .abXferClk(abXferClk),
    .abClkEnN(abClkEnN), .bOut(bOut), .bDrive(bDrive),
    .bIn(bIn), .baOutEnN(baOutEnN), .baLatchEn(baLatchEn), .baXferClk(baXferClk),
    .baClkEnN(baClkEnN), .aOut(aOut), .aDrive(aDrive)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleAll();
    abOutEnN = 1'b1; abLatchEn = 1'b0; abXferClk = 1'b0; abClkEnN = 1'b1; aIn = '0;
    baOutEnN = 1'b1; baLatchEn = 1'b0; baXferClk = 1'b0; baClkEnN = 1'b1; bIn = '0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic applyVec(input int dir, input vec_t v);
    if (dir == 0) begin
      abLatchEn = v.le; abClkEnN = v.cen; abXferClk = v.xc; abOutEnN = v.oe; aIn = v.d;
    end else begin
      baLatchEn = v.le; baClkEnN = v.cen; baXferClk = v.xc; baOutEnN = v.oe; bIn = v.d;
    end
  endtask

  initial begin
    // Watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    idleAll();
    for (int dir = 0; dir < 2; dir++) begin
      doReset();
      // R8: reset state on both ports
      @(posedge clk); #1;
      check("R8 bOut", bOut, '0);   check("R8 bDrive", W'(bDrive), '0);
      check("R8 aOut", aOut, '0);   check("R8 aDrive", W'(aDrive), '0);
      for (int i = 0; i < NV; i++) begin
        @(negedge clk);
        applyVec(dir, VEC[i]);
        @(posedge clk); #1;
        check($sformatf("R%0d vec%0d word", VEC[i].req, i), dir == 0 ? bOut : aOut, VEC[i].e);
        check($sformatf("R%0d vec%0d drive", VEC[i].req, i),
              W'(dir == 0 ? bDrive : aDrive), W'(VEC[i].drv));
        // R10 / R1: the idle direction stays untouched
        check("R10 idle word", dir == 0 ? aOut : bOut, '0);
        check("R10 idle drive", W'(dir == 0 ? aDrive : bDrive), '0);
      end
      @(negedge clk); idleAll();
    end

    // R8: transfer clock held high through reset release gives no capture
    @(negedge clk); rstN = 1'b0;
    abXferClk = 1'b1; abClkEnN = 1'b0; abLatchEn = 1'b0; abOutEnN = 1'b0; aIn = 18'h12345;
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1; check("R8 high clock at release", bOut, '0);
    @(posedge clk); #1; check("R8 high clock held", bOut, '0);
    @(negedge clk); abXferClk = 1'b0;
    @(negedge clk); abXferClk = 1'b1; aIn = 18'h3ABCD;
    @(posedge clk); #1; check("R3 capture after reset", bOut, 18'h3ABCD);
    check("R10 other word after A-to-B capture", aOut, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule